// File: doc/BRIEF.md
# Phase-Shifted Carrier PWM Modulator for a Five-Level Three-Phase Inverter

This block produces the gate drive pattern for a three-phase inverter built from two cascaded full-bridge cells per phase, giving five output voltage levels. It derives four triangular carriers from the system clock and spaces them a quarter carrier period apart. Each phase compares its own modulating sample against all four carriers, so the block drives four main gate signals per phase. Every main gate signal has a complementary partner, for 24 gate lines in all.

A control loop writes one signed modulating sample per phase and pulses a load strobe. The samples are clipped to the carrier swing and held in shadow registers. They reach the comparators only when carrier 0 is at its trough, so each carrier period compares against one consistent set of values. The carrier peak is derived from the clock and carrier frequency parameters. It is rounded so that a quarter period is a whole number of cycles.

Top module: `pspwm_modulator`

## Requirements
- R1: Each carrier is a triangle that steps by exactly one count per clock between -H and +H. Its period is 2P cycles, where P = 2*round(CLK_HZ/(4*CARRIER_HZ)) and H = P/2. Defaults: P = 2084, a 4168-cycle period.
- R2: Carrier k (k = 0..3) leads carrier 0 by k*H cycles. After reset, carrier 0 starts at its trough and rising, carrier 1 at mid-swing rising, carrier 2 at its peak, and carrier 3 at mid-swing falling.
- R3: Main gate bit `gate_hi[4*p+k]` is 1 when carrier k is greater than or equal to the active reference of phase p, and 0 otherwise. Phases are a = 0, b = 1, c = 2. The bit is registered, so it appears one clock after the carrier and reference values it was computed from.
- R4: `gate_lo` is the bitwise inverse of `gate_hi` in every cycle, including during reset.
- R5: A reference sample above +H is clipped to +H, and one below -H is clipped to -H.
- R6: A sample is taken into the shadow register on the clock edge where `ref_load` is 1. It becomes the active reference only on the edge where carrier 0 is at its trough (-H). A sample loaded between troughs leaves the outputs unchanged until that edge.
- R7: While `rst_n` is 0 at a clock edge, all `gate_hi` bits become 0 and all `gate_lo` bits become 1. The shadow and active references clear to 0, and the carriers return to their R2 start points.
- R8: A reference of -H keeps a main gate at 1 for the whole period. A reference of +H sets it high for exactly one cycle per period. For -H < m ≤ +H the high time is 2(H-m)+1 cycles per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_load | input | 1 | Strobe that captures all three reference samples |
| ref_a | input | REF_W | Signed modulating sample, phase a |
| ref_b | input | REF_W | Signed modulating sample, phase b |
| ref_c | input | REF_W | Signed modulating sample, phase c |
| gate_hi | output | 12 | Main gate signals; bit 4*phase+carrier |
| gate_lo | output | 12 | Complementary gate signals |

## Verification
The embedded assertions are checked on every cycle. They cover the carrier range and its single-count step, the quarter-period spacing of the four counters, the clipping of the shadow registers, and the rule that active references stay fixed except at a trough. They also cover the complementary outputs and the reset state of the gates.

Only the bench scenarios can show the compare result itself for each phase and carrier. The same applies to the exact cycle at which a new sample takes effect, the high time per period at the clipping limits and for values past them, and the realignment of the carriers after a reset taken in mid-run.

// File: rtl/pspwm_pkg.sv
// Shared types and helpers for the phase-shifted carrier modulator.
// Assumes four carriers per phase and three phases.
package pspwm_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } ramp_dir_e;

    localparam int unsigned NUM_CARRIERS = 4;
    localparam int unsigned NUM_PHASES   = 3;

    // Even carrier peak nearest CLK/(2*CAR), so a quarter period is whole.
    function automatic int unsigned even_peak(input int unsigned clk_hz,
                                              input int unsigned car_hz);
        return 2 * ((clk_hz + 2 * car_hz) / (4 * car_hz));
    endfunction

endpackage

// File: rtl/pspwm_carrier.sv
// One triangular carrier: an up/down counter between 0 and PEAK.
// Its signed level is the count minus PEAK/2.
// Assumes PEAK is even and at least 4; the start point sets the phase.
module pspwm_carrier
    import pspwm_pkg::*;
#(
    parameter int unsigned PEAK      = 2084,
    parameter int unsigned CW        = 12,
    parameter int unsigned SW        = 18,
    parameter int unsigned START_CNT = 0,
    parameter ramp_dir_e   START_DIR = DIR_UP
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [CW-1:0]        cnt,
    output logic signed [SW-1:0] level
);

    localparam logic signed [SW-1:0] HALF_S = SW'(PEAK / 2);

    ramp_dir_e dir;

    // Step the count once per cycle and turn around at 0 and PEAK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CW'(START_CNT);
            dir <= START_DIR;
        end else if (dir == DIR_UP) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(PEAK - 1)) dir <= DIR_DOWN;
        end else begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) dir <= DIR_UP;
        end
    end

    // Centre the count around zero for signed comparison.
    always_comb level = $signed({{(SW-CW){1'b0}}, cnt}) - HALF_S;

    AST_CARRIER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(PEAK));                                          // R1

    AST_CARRIER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1)); // R1

endmodule

// File: rtl/pspwm_ref_bank.sv
// Holds the shadow and active modulating references for each phase.
// Inputs are clipped to [-HALF, +HALF] as they are captured. Active
// values change only when the top reports a carrier-0 trough.
module pspwm_ref_bank
    import pspwm_pkg::*;
#(
    parameter int unsigned RW   = 16,
    parameter int unsigned SW   = 18,
    parameter int unsigned HALF = 1042
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 trough,
    input  logic signed [RW-1:0] raw_in  [NUM_PHASES],
    output logic signed [SW-1:0] active  [NUM_PHASES]
);

    localparam logic signed [SW-1:0] HI_LIM = SW'(HALF);
    localparam logic signed [SW-1:0] LO_LIM = -SW'(HALF);

    logic signed [SW-1:0] shadow [NUM_PHASES];

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
        logic signed [SW-1:0] wide;
        logic signed [SW-1:0] clipped;

        // Sign-extend the raw input and clip it to the carrier swing.
        always_comb begin
            wide = {{(SW-RW){raw_in[p][RW-1]}}, raw_in[p]};
            if (wide > HI_LIM)      clipped = HI_LIM;
            else if (wide < LO_LIM) clipped = LO_LIM;
            else                    clipped = wide;
        end

        // Capture on strobe; move shadow to active at a trough.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow[p] <= '0;
                active[p] <= '0;
            end else begin
                if (load)   shadow[p] <= clipped;
                if (trough) active[p] <= shadow[p];
            end
        end

        AST_SHADOW_SAT: assert property (@(posedge clk) disable iff (!rst_n)
            (shadow[p] <= HI_LIM) && (shadow[p] >= LO_LIM));       // R5

        AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !trough |=> $stable(active[p]));                        // R6
    end

endmodule

// File: rtl/pspwm_phase_cmp.sv
// Registered comparators for one phase: one per carrier, each with a
// complementary output. Assumes carrier and reference share width SW.
module pspwm_phase_cmp
    import pspwm_pkg::*;
#(
    parameter int unsigned SW = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [SW-1:0]    carrier [NUM_CARRIERS],
    input  logic signed [SW-1:0]    ref_lvl,
    output logic [NUM_CARRIERS-1:0] hi,
    output logic [NUM_CARRIERS-1:0] lo
);

    logic [NUM_CARRIERS-1:0] cmp;

    // Main decision: the carrier at or above the reference gives a 1.
    always_comb begin
        for (int k = 0; k < NUM_CARRIERS; k++) cmp[k] = (carrier[k] >= ref_lvl);
    end

    // Register both polarities so they switch on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi <= '0;
            lo <= '1;
        end else begin
            hi <= cmp;
            lo <= ~cmp;
        end
    end

    AST_COMP_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        lo == ~hi);                                                 // R4

endmodule

// File: rtl/pspwm_modulator.sv
// Top level of the phase-shifted carrier PWM modulator. Four carriers
// a quarter period apart are shared by three phase comparators.
// Assumes the clock is CLK_HZ and that the references are signed.
module pspwm_modulator
    import pspwm_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned CARRIER_HZ = 12_000,
    parameter int unsigned REF_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ref_load,
    input  logic signed [REF_W-1:0] ref_a,
    input  logic signed [REF_W-1:0] ref_b,
    input  logic signed [REF_W-1:0] ref_c,
    output logic [11:0]             gate_hi,
    output logic [11:0]             gate_lo
);

    localparam int unsigned PEAK = even_peak(CLK_HZ, CARRIER_HZ);
    localparam int unsigned HALF = PEAK / 2;
    localparam int unsigned CW   = $clog2(PEAK + 1);
    localparam int unsigned SW   = (((CW + 1) > REF_W) ? (CW + 1) : REF_W) + 1;

    logic [CW-1:0]        cnt_all [NUM_CARRIERS];
    logic signed [SW-1:0] lvl_all [NUM_CARRIERS];
    logic signed [REF_W-1:0] ref_raw [NUM_PHASES];
    logic signed [SW-1:0] ref_act [NUM_PHASES];
    logic                 trough;

    // Carriers start a quarter period apart along one triangle.
    for (genvar k = 0; k < NUM_CARRIERS; k++) begin : g_car
        localparam int unsigned    ST_CNT = (k == 0) ? 0 : ((k == 2) ? PEAK : HALF);
        localparam ramp_dir_e      ST_DIR = (k < 2) ? DIR_UP : DIR_DOWN;
        pspwm_carrier #(
            .PEAK(PEAK), .CW(CW), .SW(SW),
            .START_CNT(ST_CNT), .START_DIR(ST_DIR)
        ) u_car (
            .clk(clk), .rst_n(rst_n),
            .cnt(cnt_all[k]), .level(lvl_all[k])
        );
    end

    // Carrier 0 at its lowest count marks the reference update point.
    always_comb trough = (cnt_all[0] == '0);

    // Gather the phase inputs into an array.
    always_comb begin
        ref_raw[0] = ref_a;
        ref_raw[1] = ref_b;
        ref_raw[2] = ref_c;
    end

    pspwm_ref_bank #(.RW(REF_W), .SW(SW), .HALF(HALF)) u_refs (
        .clk(clk), .rst_n(rst_n), .load(ref_load), .trough(trough),
        .raw_in(ref_raw), .active(ref_act)
    );

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_ph
        pspwm_phase_cmp #(.SW(SW)) u_cmp (
            .clk(clk), .rst_n(rst_n),
            .carrier(lvl_all), .ref_lvl(ref_act[p]),
            .hi(gate_hi[4*p +: 4]), .lo(gate_lo[4*p +: 4])
        );
    end

    AST_QUARTER_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_all[0] == '0) |-> (cnt_all[1] == CW'(HALF)) && (cnt_all[2] == CW'(PEAK))
                              && (cnt_all[3] == CW'(HALF)));        // R2

    AST_RESET_GATES: assert property (@(posedge clk)
        !rst_n |=> (gate_hi == 12'h000) && (gate_lo == 12'hFFF));   // R7

endmodule

// File: tb/pspwm_modulator_bench.sv
module pspwm_modulator_bench;

    localparam int CLK_HZ = 1_200_000;
    localparam int CAR_HZ = 12_000;
    localparam int PK  = 2 * ((CLK_HZ + 2 * CAR_HZ) / (4 * CAR_HZ)); // 50
    localparam int HF  = PK / 2;
    localparam int PER = 2 * PK;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_load = 1'b0;
    logic signed [15:0] ref_a = '0, ref_b = '0, ref_c = '0;
    logic [11:0] gate_hi, gate_lo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit chk_en = 1'b0;

    always #5 clk = ~clk;

    pspwm_modulator #(.CLK_HZ(CLK_HZ), .CARRIER_HZ(CAR_HZ), .REF_W(16)) u_pspwm_modulator (
        .clk(clk), .rst_n(rst_n), .ref_load(ref_load),
        .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    function automatic int car_val(int k, int t);
        int p;
        p = (t + k * HF) % PER;
        return ((p <= PK) ? p : PER - p) - HF;
    endfunction

    function automatic int clip(int v);
        if (v > HF) return HF;
        if (v < -HF) return -HF;
        return v;
    endfunction

    function automatic int duty(int m);
        if (m <= -HF) return PER;
        return 2 * (HF - m) + 1;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle model of the requirements (R1 R2 R3 R5 R6 R7).
    int m_t = 0;
    int m_sh [3];
    int m_ac [3];
    logic [11:0] m_hi;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_t <= 0;
            for (int p = 0; p < 3; p++) begin m_sh[p] <= 0; m_ac[p] <= 0; end
            m_hi <= '0;
        end else begin
            m_t <= (m_t == PER - 1) ? 0 : m_t + 1;
            if (ref_load) begin
                m_sh[0] <= clip(int'(ref_a));
                m_sh[1] <= clip(int'(ref_b));
                m_sh[2] <= clip(int'(ref_c));
            end
            if (m_t == 0) for (int p = 0; p < 3; p++) m_ac[p] <= m_sh[p];
            for (int p = 0; p < 3; p++)
                for (int k = 0; k < 4; k++)
                    m_hi[4*p+k] <= (car_val(k, m_t) >= m_ac[p]);
        end
    end

    always @(negedge clk) begin
        if (chk_en) begin
            check(gate_hi == m_hi, "R1/R2/R3/R6 gate_hi", int'(gate_hi), int'(m_hi));
            check(gate_lo == ~m_hi, "R4 gate_lo", int'(gate_lo), int'(~m_hi));
        end
    end

    task automatic load3(int a, int b, int c);
        @(negedge clk);
        ref_a = 16'(a); ref_b = 16'(b); ref_c = 16'(c);
        ref_load = 1'b1;
        @(negedge clk);
        ref_load = 1'b0;
    endtask

    // Load one value into all phases, settle, then count high cycles per output.
    task automatic duty_test(int v, string tag);
        int cnt [12];
        load3(v, v, v);
        repeat (PER + 3) @(negedge clk);
        for (int i = 0; i < 12; i++) cnt[i] = 0;
        for (int n = 0; n < PER; n++) begin
            @(negedge clk);
            for (int i = 0; i < 12; i++) cnt[i] += int'(gate_hi[i]);
        end
        for (int i = 0; i < 12; i++)
            check(cnt[i] == duty(clip(v)), tag, cnt[i], duty(clip(v)));
    endtask

    initial begin
        void'($urandom(32'd20240517));
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        // R7: reset state
        check(gate_hi == 12'h000, "R7 reset gate_hi", int'(gate_hi), 0);
        check(gate_lo == 12'hFFF, "R7 reset gate_lo", int'(gate_lo), 12'hFFF);
        chk_en = 1'b1;
        rst_n = 1'b1;

        // Random loads at random times, values partly beyond the swing (R5 R6).
        for (int i = 0; i < 30; i++) begin
            repeat ($urandom_range(0, 120)) @(negedge clk);
            if ($urandom_range(0, 3) == 0)
                load3(int'($signed(16'($urandom()))), int'($signed(16'($urandom()))),
                      int'($signed(16'($urandom()))));
            else
                load3(int'($urandom_range(0, 80)) - 40, int'($urandom_range(0, 80)) - 40,
                      int'($urandom_range(0, 80)) - 40);
        end

        // Directed high-time checks.
        duty_test(-HF, "R8 duty at -H");
        duty_test(HF, "R8 duty at +H");
        duty_test(30000, "R5 duty above +H");
        duty_test(-30000, "R5 duty below -H");
        duty_test(0, "R8 duty at 0");
        duty_test(7, "R8 duty at 7");

        // Mid-run reset: carriers realign and references clear (R7 R2).
        repeat (37) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(gate_hi == 12'h000, "R7 mid-run reset gate_hi", int'(gate_hi), 0);
        check(gate_lo == 12'hFFF, "R7 mid-run reset gate_lo", int'(gate_lo), 12'hFFF);
        rst_n = 1'b1;
        repeat (PER * 2) @(negedge clk);
        duty_test(-12, "R8 duty at -12 after reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule